// File: doc/BRIEF.md
# Byte-Serial Preset/Latch Counter Channel

This block is a single up/down counter channel reached by a host through an 8-bit port. The host never touches the 24-bit count directly. It fills a preset register one byte at a time, then issues a command that moves the preset into the counter. To read the count, it freezes the count into an output latch with another command and then reads the latch back byte by byte. A byte pointer decides which byte each data access reaches. A second address, the control address, takes command and configuration bytes on writes and returns a flag byte on reads.

Counting is driven by one-cycle step pulses with a direction bit from an external decoder. Four count modes shape what happens at the ends of the range. In two of them the preset also acts as the ceiling. Two sticky toggle bits record wraps in each direction, which lets software extend the range to 25 bits. An index input can reload the counter from the preset on an edge of the selected polarity. The channel drives a filter prescaler value, the quadrature scale, and the index mode settings for the decoder next to it.

Top module: `serial_tally_chan`

## Requirements
- R1: After reset the flag byte reads 0x00, the latched count reads 0, and `filt_div`, `quad_scale`, `index_sync` and `index_pos` are 0. Step pulses are ignored until they are enabled.
- R2: On a control write, bits 6:5 pick the target: 00 command, 01 mode, 10 I/O, 11 index. A mode write stores the count mode from bits 2:1 and the quadrature scale from bits 4:3, and `quad_scale` shows that scale.
- R3: Data writes fill the preset least significant byte first. Every data access advances a shared pointer, which returns to byte 0 after the third byte. Command bit 0 (0x01) sets the pointer to byte 0.
- R4: Command 0x08 copies the preset into the counter. Command field 0x10 copies the counter into the latch. Data reads return the latch least significant byte first. Codes ORed into one byte all take effect, so 0x11 latches the count and resets the pointer.
- R5: Command 0x02 sets the counter to 0.
- R6: The flag byte holds the borrow toggle in bit 0, the carry toggle in bit 1, the sticky noise error in bit 4 and the last counted direction in bit 5 (1 means up). Command 0x04 clears both toggles. Command 0x06 clears the noise error.
- R7: A step pulse changes the counter only while I/O bit 0 is 1. In normal mode (0), counting up from 0xFFFFFF gives 0 and flips the carry toggle. Counting down from 0 gives 0xFFFFFF and flips the borrow toggle.
- R8: In range-limit mode (1), the counter holds at the preset when counting up and holds at 0 when counting down. Neither toggle changes.
- R9: In modulo-N mode (3), with N the preset, counting up from N gives 0 and flips carry. Counting down from 0 gives N and flips borrow.
- R10: In non-recycle mode (2), after a wrap through the full range the counter ignores further steps until it is reloaded from the preset or cleared.
- R11: While I/O bit 1 is 0, an index edge reloads the counter from the preset: a rising edge when the index polarity bit is 1, a falling edge when it is 0. While I/O bit 1 is 1, the index has no effect.
- R12: Index write bit 1 sets `index_pos`. Bit 0 sets `index_sync` only while the quadrature scale is nonzero. A mode write with scale 0 clears `index_sync`.
- R13: Command 0x18 copies the low preset byte to `filt_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_ctl | input | 1 | 1 selects the control/flag address, 0 the data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Latch byte at the pointer, or the flag byte |
| step_pulse | input | 1 | One-cycle count request from the decoder |
| step_up | input | 1 | Direction of the step, 1 is up |
| index_in | input | 1 | Index signal level |
| noise_hit | input | 1 | Pulse that sets the noise error flag |
| filt_div | output | 8 | Filter prescaler value |
| quad_scale | output | 2 | Quadrature scale setting |
| index_sync | output | 1 | Synchronous index selected |
| index_pos | output | 1 | Index polarity, 1 is positive |

## Verification
The assertions assume that a host write and a host read never arrive in the same cycle. They also assume that the reload and clear commands are the only sources of a counter load besides the index. The bench issues one host access per cycle and changes `step_pulse`, `index_in` and `noise_hit` only on cycles with no host access. It keeps `index_in` low whenever the index load is armed, except during the index checks.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    TGT_CMD  = 2'd0,
    TGT_MODE = 2'd1,
    TGT_IOC  = 2'd2,
    TGT_IDX  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    CM_FREE    = 2'd0,
    CM_CLAMP   = 2'd1,
    CM_ONESHOT = 2'd2,
    CM_MOD     = 2'd3
  } cmode_e;

  typedef struct packed {
    logic ptr_clr;
    logic cnt_clr;
    logic flag_clr;
    logic err_clr;
    logic preset_ld;
    logic latch_ld;
    logic psc_ld;
  } cmd_t;
endpackage

// File: rtl/tally_index.sv
module tally_index (
  input  logic clk,
  input  logic rst_n,
  input  logic index_in,
  input  logic pol_pos,
  input  logic arm_n,
  output logic idx_ld
);
  logic lvl_q;
  logic rise, fall;

  always_comb begin
    rise   = index_in & ~lvl_q;
    fall   = ~index_in & lvl_q;
    idx_ld = ~arm_n & (pol_pos ? rise : fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= index_in;
  end
endmodule

// File: rtl/tally_core.sv
module tally_core
  import tally_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             up_i,
  input  logic             ab_en_i,
  input  cmode_e           cmode_i,
  input  logic [CNT_W-1:0] ceiling_i,
  input  logic             cnt_clr_i,
  input  logic             preset_ld_i,
  input  logic             idx_ld_i,
  input  logic             flag_clr_i,
  input  logic             err_clr_i,
  input  logic             noise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bt_o,
  output logic             ct_o,
  output logic             err_o,
  output logic             ud_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, top_v;
  logic bt_q, bt_d, ct_q, ct_d, err_q, err_d, ud_q, ud_d, halt_q, halt_d;
  logic step_ok;

  always_comb begin
    top_v   = (cmode_i == CM_CLAMP || cmode_i == CM_MOD) ? ceiling_i : MAXV;
    step_ok = ab_en_i & pulse_i & ~(halt_q & (cmode_i == CM_ONESHOT));
    cnt_d   = cnt_q;
    bt_d    = bt_q;
    ct_d    = ct_q;
    ud_d    = ud_q;
    halt_d  = halt_q;
    if (cnt_clr_i) begin
      cnt_d  = '0;
      halt_d = 1'b0;
    end else if (preset_ld_i || idx_ld_i) begin
      cnt_d  = ceiling_i;
      halt_d = 1'b0;
    end else if (step_ok) begin
      ud_d = up_i;
      if (up_i) begin
        if (cnt_q == top_v) begin
          case (cmode_i)
            CM_CLAMP:   cnt_d = cnt_q;
            CM_ONESHOT: begin cnt_d = '0; ct_d = ~ct_q; halt_d = 1'b1; end
            default:    begin cnt_d = '0; ct_d = ~ct_q; end
          endcase
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          case (cmode_i)
            CM_CLAMP:   cnt_d = cnt_q;
            CM_MOD:     begin cnt_d = ceiling_i; bt_d = ~bt_q; end
            CM_ONESHOT: begin cnt_d = MAXV; bt_d = ~bt_q; halt_d = 1'b1; end
            default:    begin cnt_d = MAXV; bt_d = ~bt_q; end
          endcase
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
    if (flag_clr_i) begin
      bt_d = 1'b0;
      ct_d = 1'b0;
    end
    err_d = err_clr_i ? 1'b0 : (err_q | noise_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bt_q   <= 1'b0;
      ct_q   <= 1'b0;
      err_q  <= 1'b0;
      ud_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bt_q   <= bt_d;
      ct_q   <= ct_d;
      err_q  <= err_d;
      ud_q   <= ud_d;
      halt_q <= halt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign bt_o  = bt_q;
  assign ct_o  = ct_q;
  assign err_o = err_q;
  assign ud_o  = ud_q;

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_i && !cnt_clr_i && !preset_ld_i && !idx_ld_i) |=> $stable(cnt_q));

  // R8
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode_i == CM_CLAMP && ab_en_i && pulse_i && up_i && cnt_q == ceiling_i &&
     !cnt_clr_i && !preset_ld_i && !idx_ld_i) |=> $stable(cnt_q));

  // R9
  mod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode_i == CM_MOD && ab_en_i && pulse_i && up_i && cnt_q == ceiling_i &&
     !cnt_clr_i && !preset_ld_i && !idx_ld_i) |=> (cnt_q == '0));

  // R10
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode_i == CM_ONESHOT && halt_q && !cnt_clr_i && !preset_ld_i && !idx_ld_i)
    |=> $stable(cnt_q));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr_i) |=> err_q);
endmodule

// File: rtl/tally_hostif.sv
module tally_hostif
  import tally_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NB     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 sel_ctrl,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic [BYTE_W*NB-1:0] cnt_val,
  input  logic [BYTE_W-1:0]    flags,
  output logic [BYTE_W-1:0]    rdata,
  output cmd_t                 cmd,
  output logic [BYTE_W*NB-1:0] preset,
  output cmode_e               cmode,
  output logic [1:0]           scale,
  output logic                 ab_en,
  output logic                 idx_arm_n,
  output logic                 idx_sync,
  output logic                 idx_pos,
  output logic [BYTE_W-1:0]    filt_div
);
  localparam int CNT_W = BYTE_W * NB;
  localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NB - 1);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0]  preset_q, preset_d, latch_q, latch_d;
  cmode_e            cmode_q, cmode_d;
  logic [1:0]        scale_q, scale_d;
  logic              ab_q, ab_d, arm_n_q, arm_n_d, sync_q, sync_d, pos_q, pos_d;
  logic [BYTE_W-1:0] psc_q, psc_d, rd_byte;
  tgt_e              tgt;
  logic              ctl_wr, dat_wr, dat_acc;

  always_comb begin
    tgt     = tgt_e'(wdata[6:5]);
    ctl_wr  = wr_en & sel_ctrl;
    dat_wr  = wr_en & ~sel_ctrl;
    dat_acc = (wr_en | rd_en) & ~sel_ctrl;
    cmd     = '0;
    if (ctl_wr && tgt == TGT_CMD) begin
      cmd.ptr_clr   = wdata[0];
      cmd.cnt_clr   = (wdata[2:1] == 2'b01);
      cmd.flag_clr  = (wdata[2:1] == 2'b10);
      cmd.err_clr   = (wdata[2:1] == 2'b11);
      cmd.preset_ld = (wdata[4:3] == 2'b01);
      cmd.latch_ld  = (wdata[4:3] == 2'b10);
      cmd.psc_ld    = (wdata[4:3] == 2'b11);
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (cmd.ptr_clr)  ptr_d = '0;
    else if (dat_acc) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_pre_byte
      always_comb begin
        preset_d[g*BYTE_W +: BYTE_W] = preset_q[g*BYTE_W +: BYTE_W];
        if (dat_wr && ptr_q == PTR_W'(g)) preset_d[g*BYTE_W +: BYTE_W] = wdata;
      end
    end
  endgenerate

  always_comb begin
    latch_d = cmd.latch_ld ? cnt_val : latch_q;
    psc_d   = cmd.psc_ld ? preset_q[BYTE_W-1:0] : psc_q;
    cmode_d = cmode_q;
    scale_d = scale_q;
    ab_d    = ab_q;
    arm_n_d = arm_n_q;
    sync_d  = sync_q;
    pos_d   = pos_q;
    if (ctl_wr) begin
      case (tgt)
        TGT_MODE: begin
          cmode_d = cmode_e'(wdata[2:1]);
          scale_d = wdata[4:3];
          if (wdata[4:3] == 2'b00) sync_d = 1'b0;
        end
        TGT_IOC: begin
          ab_d    = wdata[0];
          arm_n_d = wdata[1];
        end
        TGT_IDX: begin
          sync_d = wdata[0] & (scale_q != 2'b00);
          pos_d  = wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NB; i++)
      if (ptr_q == PTR_W'(i)) rd_byte = latch_q[i*BYTE_W +: BYTE_W];
    rdata = sel_ctrl ? flags : rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      preset_q <= '0;
      latch_q  <= '0;
      psc_q    <= '0;
      cmode_q  <= CM_FREE;
      scale_q  <= '0;
      ab_q     <= 1'b0;
      arm_n_q  <= 1'b0;
      sync_q   <= 1'b0;
      pos_q    <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      preset_q <= preset_d;
      latch_q  <= latch_d;
      psc_q    <= psc_d;
      cmode_q  <= cmode_d;
      scale_q  <= scale_d;
      ab_q     <= ab_d;
      arm_n_q  <= arm_n_d;
      sync_q   <= sync_d;
      pos_q    <= pos_d;
    end
  end

  assign preset    = preset_q;
  assign cmode     = cmode_q;
  assign scale     = scale_q;
  assign ab_en     = ab_q;
  assign idx_arm_n = arm_n_q;
  assign idx_sync  = sync_q;
  assign idx_pos   = pos_q;
  assign filt_div  = psc_q;

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_LAST);

  // R12
  sync_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (scale_q != 2'b00));

  // R13
  psc_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.psc_ld |=> (psc_q == $past(preset_q[BYTE_W-1:0])));
endmodule

// File: rtl/serial_tally_chan.sv
module serial_tally_chan
  import tally_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_ctl,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              step_pulse,
  input  logic              step_up,
  input  logic              index_in,
  input  logic              noise_hit,
  output logic [BYTE_W-1:0] filt_div,
  output logic [1:0]        quad_scale,
  output logic              index_sync,
  output logic              index_pos
);
  localparam int NB = CNT_W / BYTE_W;

  cmd_t             cmd;
  cmode_e           cmode;
  logic [CNT_W-1:0] preset, cnt;
  logic             ab_en, arm_n, idx_ld, bt, ct, err, ud;
  logic [BYTE_W-1:0] flags;

  always_comb begin
    flags    = '0;
    flags[0] = bt;
    flags[1] = ct;
    flags[4] = err;
    flags[5] = ud;
  end

  tally_hostif #(.BYTE_W(BYTE_W), .NB(NB)) u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .rd_en(host_rd),
    .sel_ctrl(host_ctl), .wdata(host_wdata), .cnt_val(cnt), .flags(flags),
    .rdata(host_rdata), .cmd(cmd), .preset(preset), .cmode(cmode),
    .scale(quad_scale), .ab_en(ab_en), .idx_arm_n(arm_n),
    .idx_sync(index_sync), .idx_pos(index_pos), .filt_div(filt_div)
  );

  tally_index u_idx (
    .clk(clk), .rst_n(rst_n), .index_in(index_in), .pol_pos(index_pos),
    .arm_n(arm_n), .idx_ld(idx_ld)
  );

  tally_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .pulse_i(step_pulse), .up_i(step_up),
    .ab_en_i(ab_en), .cmode_i(cmode), .ceiling_i(preset),
    .cnt_clr_i(cmd.cnt_clr), .preset_ld_i(cmd.preset_ld), .idx_ld_i(idx_ld),
    .flag_clr_i(cmd.flag_clr), .err_clr_i(cmd.err_clr), .noise_i(noise_hit),
    .cnt_o(cnt), .bt_o(bt), .ct_o(ct), .err_o(err), .ud_o(ud)
  );
endmodule

// File: tb/test_serial_tally_chan.sv
module test_serial_tally_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_ctl = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic step_pulse = 1'b0, step_up = 1'b0, index_in = 1'b0, noise_hit = 1'b0;
  logic [7:0] filt_div;
  logic [1:0] quad_scale;
  logic index_sync, index_pos;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_tally_chan i_serial_tally_chan (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_ctl(host_ctl), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .step_pulse(step_pulse), .step_up(step_up), .index_in(index_in),
    .noise_hit(noise_hit), .filt_div(filt_div), .quad_scale(quad_scale),
    .index_sync(index_sync), .index_pos(index_pos)
  );

  // vector: {op[1:0], ctl, data[7:0], exp[7:0], tag[3:0]}; op 0 write, 1 read, 2 step
  localparam int NV = 23;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'h01, 8'h00, 4'd0},
    {2'd0, 1'b0, 8'h56, 8'h00, 4'd0},
    {2'd0, 1'b0, 8'h34, 8'h00, 4'd0},
    {2'd0, 1'b0, 8'h12, 8'h00, 4'd0},
    {2'd0, 1'b1, 8'h08, 8'h00, 4'd0},
    {2'd0, 1'b1, 8'h11, 8'h00, 4'd0},
    {2'd1, 1'b0, 8'h00, 8'h56, 4'd4},
    {2'd1, 1'b0, 8'h00, 8'h34, 4'd4},
    {2'd1, 1'b0, 8'h00, 8'h12, 4'd4},
    {2'd1, 1'b0, 8'h00, 8'h56, 4'd3},
    {2'd0, 1'b1, 8'h43, 8'h00, 4'd0},
    {2'd2, 1'b0, 8'h01, 8'h00, 4'd0},
    {2'd2, 1'b0, 8'h01, 8'h00, 4'd0},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd0},
    {2'd1, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd2, 1'b0, 8'h01, 8'h00, 4'd0},
    {2'd1, 1'b1, 8'h00, 8'h20, 4'd6},
    {2'd0, 1'b1, 8'h42, 8'h00, 4'd0},
    {2'd2, 1'b0, 8'h01, 8'h00, 4'd0},
    {2'd0, 1'b1, 8'h11, 8'h00, 4'd0},
    {2'd1, 1'b0, 8'h00, 8'h58, 4'd7},
    {2'd1, 1'b0, 8'h00, 8'h34, 4'd7},
    {2'd1, 1'b1, 8'h00, 8'h20, 4'd7}
  };

  function automatic string tag_of(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] b);
    @(negedge clk);
    host_ctl = ctl; host_wr = 1'b1; host_wdata = b;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic ctl, output logic [7:0] b);
    @(negedge clk);
    host_ctl = ctl; host_rd = 1'b1;
    #1 b = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic step(input logic up);
    @(negedge clk);
    step_pulse = 1'b1; step_up = up;
    @(posedge clk); #1;
    step_pulse = 1'b0;
  endtask

  task automatic load_preset(input logic [23:0] v);
    wr(1'b1, 8'h01);
    wr(1'b0, v[7:0]);
    wr(1'b0, v[15:8]);
    wr(1'b0, v[23:16]);
  endtask

  task automatic chk_latch(input string tag, input logic [23:0] exp);
    logic [7:0] b0, b1, b2;
    wr(1'b1, 8'h11);
    rd(1'b0, b0);
    rd(1'b0, b1);
    rd(1'b0, b2);
    check(tag, {8'h00, b2, b1, b0}, {8'h00, exp});
  endtask

  task automatic chk_flags(input string tag, input logic [7:0] exp);
    logic [7:0] f;
    rd(1'b1, f);
    check(tag, {24'h0, f}, {24'h0, exp});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_flags("R1", 8'h00);
    check("R1", {24'h0, filt_div}, 32'h0);
    check("R1", {28'h0, quad_scale, index_sync, index_pos}, 32'h0);
    step(1'b1);
    chk_latch("R1", 24'h000000);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][22:21])
        2'd0: wr(VEC[v][20], VEC[v][19:12]);
        2'd1: begin
          rd(VEC[v][20], b);
          check(tag_of(VEC[v][3:0]), {24'h0, b}, {24'h0, VEC[v][11:4]});
        end
        default: step(VEC[v][12]);
      endcase
    end

    // R7 normal mode wraps
    wr(1'b1, 8'h43);
    load_preset(24'hFFFFFF);
    wr(1'b1, 8'h08);
    step(1'b1);
    chk_latch("R7", 24'h000000);
    chk_flags("R7", 8'h22);
    step(1'b0);
    chk_latch("R7", 24'hFFFFFF);
    chk_flags("R7", 8'h03);
    wr(1'b1, 8'h04);
    chk_flags("R6", 8'h00);

    // R8 range limit, R5 counter clear
    wr(1'b1, 8'h22);
    load_preset(24'h000005);
    wr(1'b1, 8'h08);
    step(1'b1);
    chk_latch("R8", 24'h000005);
    wr(1'b1, 8'h02);
    chk_latch("R5", 24'h000000);
    step(1'b0);
    chk_latch("R8", 24'h000000);
    chk_flags("R8", 8'h00);

    // R9 modulo-N
    wr(1'b1, 8'h26);
    load_preset(24'h000003);
    step(1'b0);
    chk_latch("R9", 24'h000003);
    chk_flags("R9", 8'h01);
    step(1'b1);
    chk_latch("R9", 24'h000000);
    chk_flags("R9", 8'h23);
    wr(1'b1, 8'h04);

    // R10 non-recycle
    wr(1'b1, 8'h24);
    load_preset(24'hFFFFFF);
    wr(1'b1, 8'h08);
    step(1'b1);
    step(1'b1);
    step(1'b1);
    chk_latch("R10", 24'h000000);
    wr(1'b1, 8'h08);
    step(1'b0);
    chk_latch("R10", 24'hFFFFFE);

    // R6 noise error flag
    wr(1'b1, 8'h04);
    @(negedge clk); noise_hit = 1'b1;
    @(posedge clk); #1 noise_hit = 1'b0;
    chk_flags("R6", 8'h10);
    wr(1'b1, 8'h06);
    chk_flags("R6", 8'h00);

    // R13 prescaler copy
    load_preset(24'h0000A5);
    wr(1'b1, 8'h18);
    check("R13", {24'h0, filt_div}, 32'hA5);

    // R11 index reload
    wr(1'b1, 8'h20);
    load_preset(24'h000777);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h62);
    check("R12", {31'h0, index_pos}, 32'h1);
    wr(1'b1, 8'h41);
    @(negedge clk); index_in = 1'b1;
    @(posedge clk); #1;
    chk_latch("R11", 24'h000777);
    wr(1'b1, 8'h43);
    @(negedge clk); index_in = 1'b0;
    @(posedge clk); #1;
    wr(1'b1, 8'h02);
    @(negedge clk); index_in = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); index_in = 1'b0;
    @(posedge clk); #1;
    chk_latch("R11", 24'h000000);

    // R12 synchronous index needs a quadrature scale; R2 field positions
    wr(1'b1, 8'h61);
    check("R12", {31'h0, index_sync}, 32'h0);
    wr(1'b1, 8'h28);
    check("R2", {30'h0, quad_scale}, 32'h1);
    wr(1'b1, 8'h61);
    check("R12", {30'h0, index_sync, index_pos}, 32'h2);
    wr(1'b1, 8'h20);
    check("R12", {31'h0, index_sync}, 32'h0);
    check("R2", {30'h0, quad_scale}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule